// File: doc/BRIEF.md
# Receive Interrupt Moderation Controller

This block decides when the receive path raises interrupt causes. It watches completion pulses from the receive DMA engine and evaluates them against a set of delay and threshold settings. Two countdown timers run in units of a prescaled interrupt-clock tick. The per-frame timer is reloaded by every finished frame, so it fires only after traffic has gone quiet. The absolute timer is armed by the first finished frame while it is idle, and later frames do not push it back. If both delays are programmed to zero, the timer cause is raised at once.

Three other checks run on each finished frame. A small-frame cause is raised when the frame is short. A low-descriptor cause is raised when the count of free descriptors falls to a chosen fraction of the ring. A descriptor-writeback request is raised whenever the receive FIFO has drained or the ring has run dry. Only completions that carry the end-of-packet flag count as a finished frame. Completions of intermediate buffers of a multi-buffer frame can still request a writeback, but they raise no interrupt cause.

Top module: `rx_irq_moderator`

## Requirements
- R1: After reset all four outputs are low and both timers are idle.
- R2: When `pktDelay` is nonzero, a completion with `frameEop` high reloads the per-frame timer to `pktDelay`. Without a further reload, `rxTimerIrq` pulses in the cycle after the `pktDelay`-th following `intTick`.
- R3: When `absDelay` is nonzero, an end-of-packet completion loads the absolute timer only if that timer is idle (zero). A running absolute timer is neither reloaded nor extended, and it fires on reaching zero after `absDelay` ticks.
- R4: An end-of-packet completion with both `pktDelay` and `absDelay` equal to zero makes `rxTimerIrq` pulse in the next cycle.
- R5: When either timer reaches zero, one `rxTimerIrq` pulse is produced and both timers return to idle, unless a timer is being loaded in that same cycle. A load always takes priority over a clear or a countdown.
- R6: A completion with `frameEop` low does not touch either timer and raises none of `rxTimerIrq`, `smallPktIrq` or `minThreshIrq`.
- R7: `smallPktIrq` pulses in the cycle after an end-of-packet completion whose `frameLen` is less than or equal to `smallThresh`.
- R8: `minThreshIrq` pulses in the cycle after an end-of-packet completion when `descLeft` is at or below a fraction of `ringLen`, computed with the fraction rounded down. The fraction is selected by `threshSel`: 0 selects ringLen>>1, 1 selects ringLen>>2 and 2 selects ringLen>>3. Encoding 3 never fires.
- R9: `wbReq` pulses in the cycle after any completion (with or without end-of-packet) when `fifoEmpty` is high or `descLeft` is zero.
- R10: Every output is registered and lasts a single cycle per cause. Without a completion in a cycle, `wbReq`, `smallPktIrq` and `minThreshIrq` are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameDone | input | 1 | One-cycle pulse: a receive buffer DMA has completed |
| frameEop | input | 1 | With frameDone: this buffer ends the frame |
| frameLen | input | LEN_W | Length of the completed frame in bytes |
| descLeft | input | RING_W | Free receive descriptors remaining |
| ringLen | input | RING_W | Total descriptors in the ring |
| fifoEmpty | input | 1 | Receive FIFO holds no further frames |
| pktDelay | input | DLY_W | Per-frame delay in ticks, 0 disables |
| absDelay | input | DLY_W | Absolute delay in ticks, 0 disables |
| smallThresh | input | LEN_W | Small-frame length threshold |
| threshSel | input | 2 | Low-descriptor fraction select |
| intTick | input | 1 | Interrupt-clock prescaler tick |
| rxTimerIrq | output | 1 | Receive timer cause pulse |
| smallPktIrq | output | 1 | Small-frame cause pulse |
| minThreshIrq | output | 1 | Low-descriptor cause pulse |
| wbReq | output | 1 | Descriptor writeback request pulse |

## Verification
The hardest case to reach is a collision at a timer edge. One example is a finished frame arriving in the very cycle that a tick would carry a timer from one to zero. Another is the absolute timer expiring while the per-frame timer is still running. The stimulus uses delays of only a few ticks, dense ticks and frequent completions, so these collisions recur many times. A cycle-accurate bench model predicts every output, including the load-over-clear priority.

// File: rtl/rxim_pkg.sv
package rxim_pkg;
  typedef struct packed {
    logic eopEvt;     // finished frame (end-of-packet completion)
    logic loadPkt;    // reload per-frame timer
    logic armAbs;     // request absolute timer arm (taken only if idle)
    logic immediate;  // both delays zero: raise timer cause now
    logic wbCheck;    // any completion: evaluate writeback
  } ctrl_strobe_t;
endpackage

// File: rtl/rxim_ctrl.sv
module rxim_ctrl
  import rxim_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             frameDone,
  input  logic             frameEop,
  input  logic [DLY_W-1:0] pktDelay,
  input  logic [DLY_W-1:0] absDelay,
  output ctrl_strobe_t     strobe
);
  logic pktOn;
  logic absOn;

  always_comb begin
    pktOn            = (pktDelay != '0);
    absOn            = (absDelay != '0);
    strobe.eopEvt    = frameDone && frameEop;
    strobe.loadPkt   = strobe.eopEvt && pktOn;
    strobe.armAbs    = strobe.eopEvt && absOn;
    strobe.immediate = strobe.eopEvt && !pktOn && !absOn;
    strobe.wbCheck   = frameDone;
  end
endmodule

// File: rtl/rxim_datapath.sv
module rxim_datapath
  import rxim_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int RING_W = 12,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic              intTick,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [LEN_W-1:0]  smallThresh,
  input  logic [RING_W-1:0] descLeft,
  input  logic [RING_W-1:0] ringLen,
  input  logic              fifoEmpty,
  input  logic [1:0]        threshSel,
  input  logic [DLY_W-1:0]  pktDelay,
  input  logic [DLY_W-1:0]  absDelay,
  output logic              rxTimerIrq,
  output logic              smallPktIrq,
  output logic              minThreshIrq,
  output logic              wbReq
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0]  pktCnt, absCnt;
  logic [DLY_W-1:0]  pktNext, absNext;
  logic              absLoad, pktFire, absFire, timerFire;
  logic [RING_W-1:0] ringFrac;
  logic              fracValid;

  // timer sequencing
  always_comb begin
    absLoad   = strobe.armAbs && (absCnt == '0);
    pktFire   = intTick && (pktCnt == ONE) && !strobe.loadPkt;
    absFire   = intTick && (absCnt == ONE);
    timerFire = pktFire || absFire;

    if (strobe.loadPkt)              pktNext = pktDelay;
    else if (timerFire)              pktNext = '0;
    else if (intTick && pktCnt != 0) pktNext = pktCnt - ONE;
    else                             pktNext = pktCnt;

    if (absLoad)                     absNext = absDelay;
    else if (timerFire)              absNext = '0;
    else if (intTick && absCnt != 0) absNext = absCnt - ONE;
    else                             absNext = absCnt;
  end

  // ring fraction by shifting
  always_comb begin
    fracValid = 1'b1;
    unique case (threshSel)
      2'd0:    ringFrac = ringLen >> 1;
      2'd1:    ringFrac = ringLen >> 2;
      2'd2:    ringFrac = ringLen >> 3;
      default: begin
        ringFrac  = '0;
        fracValid = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktCnt       <= '0;
      absCnt       <= '0;
      rxTimerIrq   <= 1'b0;
      smallPktIrq  <= 1'b0;
      minThreshIrq <= 1'b0;
      wbReq        <= 1'b0;
    end else begin
      pktCnt       <= pktNext;
      absCnt       <= absNext;
      rxTimerIrq   <= timerFire || strobe.immediate;
      smallPktIrq  <= strobe.eopEvt && (frameLen <= smallThresh);
      minThreshIrq <= strobe.eopEvt && fracValid && (descLeft <= ringFrac);
      wbReq        <= strobe.wbCheck && (fifoEmpty || descLeft == '0);
    end
  end
endmodule

// File: rtl/rx_irq_moderator.sv
module rx_irq_moderator
  import rxim_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int RING_W = 12,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic              frameEop,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [RING_W-1:0] descLeft,
  input  logic [RING_W-1:0] ringLen,
  input  logic              fifoEmpty,
  input  logic [DLY_W-1:0]  pktDelay,
  input  logic [DLY_W-1:0]  absDelay,
  input  logic [LEN_W-1:0]  smallThresh,
  input  logic [1:0]        threshSel,
  input  logic              intTick,
  output logic              rxTimerIrq,
  output logic              smallPktIrq,
  output logic              minThreshIrq,
  output logic              wbReq
);
  ctrl_strobe_t strobe;

  rxim_ctrl #(.DLY_W(DLY_W)) i_ctrl (
    .frameDone (frameDone),
    .frameEop  (frameEop),
    .pktDelay  (pktDelay),
    .absDelay  (absDelay),
    .strobe    (strobe)
  );

  rxim_datapath #(.LEN_W(LEN_W), .RING_W(RING_W), .DLY_W(DLY_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .intTick      (intTick),
    .frameLen     (frameLen),
    .smallThresh  (smallThresh),
    .descLeft     (descLeft),
    .ringLen      (ringLen),
    .fifoEmpty    (fifoEmpty),
    .threshSel    (threshSel),
    .pktDelay     (pktDelay),
    .absDelay     (absDelay),
    .rxTimerIrq   (rxTimerIrq),
    .smallPktIrq  (smallPktIrq),
    .minThreshIrq (minThreshIrq),
    .wbReq        (wbReq)
  );
endmodule

// File: rtl/rxim_checker.sv
module rxim_checker #(
  parameter int LEN_W  = 14,
  parameter int RING_W = 12,
  parameter int DLY_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameDone,
  input logic              frameEop,
  input logic [LEN_W-1:0]  frameLen,
  input logic [RING_W-1:0] descLeft,
  input logic              fifoEmpty,
  input logic [DLY_W-1:0]  pktDelay,
  input logic [DLY_W-1:0]  absDelay,
  input logic [LEN_W-1:0]  smallThresh,
  input logic [1:0]        threshSel,
  input logic              rxTimerIrq,
  input logic              smallPktIrq,
  input logic              minThreshIrq,
  input logic              wbReq
);
  p_immediate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && frameEop && pktDelay == 0 && absDelay == 0) |=> rxTimerIrq);

  p_noeop_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !frameEop) |=> (!smallPktIrq && !minThreshIrq));

  p_small_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && frameEop && frameLen <= smallThresh) |=> smallPktIrq);

  p_sel_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && threshSel == 2'd3) |=> !minThreshIrq);

  p_writeback_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && (fifoEmpty || descLeft == 0)) |=> wbReq);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> (!wbReq && !smallPktIrq && !minThreshIrq));
endmodule

bind rx_irq_moderator rxim_checker #(.LEN_W(LEN_W), .RING_W(RING_W), .DLY_W(DLY_W)) i_rxim_checker (
  .clk          (clk),
  .rstN         (rstN),
  .frameDone    (frameDone),
  .frameEop     (frameEop),
  .frameLen     (frameLen),
  .descLeft     (descLeft),
  .fifoEmpty    (fifoEmpty),
  .pktDelay     (pktDelay),
  .absDelay     (absDelay),
  .smallThresh  (smallThresh),
  .threshSel    (threshSel),
  .rxTimerIrq   (rxTimerIrq),
  .smallPktIrq  (smallPktIrq),
  .minThreshIrq (minThreshIrq),
  .wbReq        (wbReq)
);

// File: tb/test_rx_irq_moderator.sv
module test_rx_irq_moderator;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W  = 14;
  localparam int RING_W = 12;
  localparam int DLY_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              frameDone = 1'b0, frameEop = 1'b0, fifoEmpty = 1'b0, intTick = 1'b0;
  logic [LEN_W-1:0]  frameLen = '0, smallThresh = '0;
  logic [RING_W-1:0] descLeft = '0, ringLen = '0;
  logic [DLY_W-1:0]  pktDelay = '0, absDelay = '0;
  logic [1:0]        threshSel = '0;
  logic              rxTimerIrq, smallPktIrq, minThreshIrq, wbReq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int pktM = 0;
  int absM = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_irq_moderator #(.LEN_W(LEN_W), .RING_W(RING_W), .DLY_W(DLY_W)) i_rx_irq_moderator (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameEop(frameEop),
    .frameLen(frameLen), .descLeft(descLeft), .ringLen(ringLen), .fifoEmpty(fifoEmpty),
    .pktDelay(pktDelay), .absDelay(absDelay), .smallThresh(smallThresh),
    .threshSel(threshSel), .intTick(intTick), .rxTimerIrq(rxTimerIrq),
    .smallPktIrq(smallPktIrq), .minThreshIrq(minThreshIrq), .wbReq(wbReq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ringFrac(input int ring, input int sel);
    if (sel == 0) return ring >> 1;
    if (sel == 1) return ring >> 2;
    return ring >> 3;
  endfunction

  // One clock: predict from current inputs and model, clock, then compare.
  task automatic cycle();
    bit evt, pktLoad, absLoad, pktFire, absFire, fire;
    bit expT, expS, expM, expW;
    evt     = frameDone && frameEop;
    pktLoad = evt && pktDelay != 0;
    absLoad = evt && absDelay != 0 && absM == 0;
    pktFire = intTick && pktM == 1 && !pktLoad;
    absFire = intTick && absM == 1;
    fire    = pktFire || absFire;
    expT = fire || (evt && pktDelay == 0 && absDelay == 0);
    expS = evt && (frameLen <= smallThresh);
    expM = evt && threshSel != 2'd3 && (int'(descLeft) <= ringFrac(int'(ringLen), int'(threshSel)));
    expW = frameDone && (fifoEmpty || descLeft == 0);
    if (pktLoad) pktM = int'(pktDelay);
    else if (fire) pktM = 0;
    else if (intTick && pktM != 0) pktM--;
    if (absLoad) absM = int'(absDelay);
    else if (fire) absM = 0;
    else if (intTick && absM != 0) absM--;
    @(posedge clk);
    #1;
    check("R2 R3 R4 R5 R6 rxTimerIrq", rxTimerIrq, expT);
    check("R7 R6 smallPktIrq", smallPktIrq, expS);
    check("R8 R6 minThreshIrq", minThreshIrq, expM);
    check("R9 R10 wbReq", wbReq, expW);
  endtask

  task automatic idle(input int n, input bit tick);
    for (int i = 0; i < n; i++) begin
      frameDone = 0; intTick = tick;
      cycle();
    end
    intTick = 0;
  endtask

  task automatic frame(input bit eop, input int len, input int left);
    frameDone = 1; frameEop = eop; frameLen = LEN_W'(len); descLeft = RING_W'(left);
    intTick = 0;
    cycle();
    frameDone = 0; frameEop = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs low in reset and right after
    check("R1 rxTimerIrq", rxTimerIrq, 1'b0);
    check("R1 smallPktIrq", smallPktIrq, 1'b0);
    check("R1 minThreshIrq", minThreshIrq, 1'b0);
    check("R1 wbReq", wbReq, 1'b0);
    rstN = 1;
    ringLen = 12'd64; smallThresh = 14'd60;

    // Directed R4: immediate cause
    pktDelay = 0; absDelay = 0;
    frame(1, 100, 50);
    idle(2, 1);

    // Directed R2: per-frame timer restarted by later frames
    pktDelay = 3;
    frame(1, 100, 50);
    idle(2, 1);
    frame(1, 100, 50);
    idle(5, 1);

    // Directed R3: absolute timer not extended by later frames
    pktDelay = 0; absDelay = 4;
    frame(1, 100, 50);
    idle(1, 1);
    frame(1, 100, 50);
    idle(1, 1);
    frame(1, 100, 50);
    idle(4, 1);

    // Directed R6: non-EOP completion, R9 writeback still raised
    fifoEmpty = 1;
    frame(0, 10, 0);
    fifoEmpty = 0;
    idle(6, 1);

    // Directed R8: each threshold select at its boundary
    absDelay = 0; pktDelay = 9;
    for (int s = 0; s < 4; s++) begin
      threshSel = 2'(s);
      frame(1, 200, ringFrac(64, s));
      frame(1, 200, ringFrac(64, s) + 1);
    end
    // R7 boundary
    frame(1, 60, 50);
    frame(1, 61, 50);
    idle(12, 1);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 64) == 0) begin
        pktDelay = DLY_W'($urandom % 6);
        absDelay = DLY_W'($urandom % 8);
        threshSel = 2'($urandom % 4);
        ringLen = RING_W'($urandom % 256);
        smallThresh = LEN_W'($urandom % 128);
      end
      frameDone = (($urandom % 4) == 0);
      frameEop  = (($urandom % 4) != 0);
      frameLen  = LEN_W'($urandom % 160);
      descLeft  = RING_W'(($urandom % 8 == 0) ? 0 : ($urandom % 256));
      fifoEmpty = (($urandom % 3) == 0);
      intTick   = (($urandom % 3) != 0);
      cycle();
    end
    frameDone = 0; intTick = 0;
    idle(2, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule